// File: doc/BRIEF.md
# Converter startup and fault sequencer

This block is the synchronous supervisor for a digitally controlled buck power stage. It decides when the switching stage may run, and when the gates must be released to high impedance or held off. It also produces the soft-start reference as a digital ramp and reports when the output is good. The comparators that watch the rails, the feedback node and the current sense sit outside the block. Their results arrive as single-bit flags. Each flag passes through a synchronizer before the controller acts on it.

The soft-start ramp follows the digitized feedback code while enable is low, so the next start begins from any voltage already present on the output. Once enable is high and both supply rails are good, the ramp climbs by a programmable step on each ramp tick and stops at the reference code. When it reaches the reference, the block enters regulation. An overcurrent event clears the ramp and starts the soft start again. A fixed number of such events locks the stage off until enable is toggled or a rail drops. An overvoltage locks the stage off until a rail is lost, and toggling enable does not clear it.

Top module: `buck_seq_ctrl`

## Requirements
- R1: Switching (`sw_en_o` = 1) begins only when both rail-good flags and enable are high. The first running state is soft start.
- R2: If either rail-good flag goes low, the block enters OFF from any state. This stops switching and clears the overcurrent count and any overvoltage lockout.
- R3: An overcurrent flag during soft start or regulation gives one cycle in OC_RESTART. In that cycle `gate_hiz_o` and `ss_clr_o` are high and switching stops. The ramp then clears to 0 and a new soft start begins.
- R4: The OC_LIMIT-th counted overcurrent event (3 by default) enters LATCHED_OFF. There `latched_o` and `gate_hiz_o` are high, and the block stays there while enable stays high.
- R5: The overcurrent count builds up across restarts. It is cleared only while enable is low or a rail-good flag is low.
- R6: `pgood_o` is high only while the block is switching and both the soft-start-above-delay flag and the output-not-undervoltage flag are high.
- R7: An overvoltage flag while the block is switching or restarting enters OV_LATCHED. There switching stops, `pgood_o` is low and `latched_o` is high. Toggling enable has no effect; only the loss of a rail leaves this state.
- R8: While the block is in OFF, `ss_level_o` loads `fb_code_i` on every cycle.
- R9: While the block is switching, the ramp adds `ss_step_i` once every TICK_DIV cycles and saturates at REF_CODE. Soft start moves to regulation in the cycle after the ramp holds REF_CODE.
- R10: A flag value seen at a clock edge reaches the state and the registered outputs at the SYNC_STAGES-th edge after that one (the third edge for the default depth of 2). The ramp follows the state one edge later.
- R11: `state_oh_o` is one-hot, with these bits: OFF=0, SOFTSTART=1, REGULATE=2, OC_RESTART=3, LATCHED_OFF=4, OV_LATCHED=5. After reset only bit 0 is set and every other output is 0.
- R12: Enable going low during soft start, regulation or an overcurrent restart returns the block to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable request |
| rail_a_ok_i | input | 1 | First monitored supply above its falling threshold |
| rail_b_ok_i | input | 1 | Second monitored supply above its falling threshold |
| oc_i | input | 1 | Overcurrent seen in this switching cycle |
| ov_i | input | 1 | Feedback above the overvoltage threshold |
| uv_ok_i | input | 1 | Feedback above the undervoltage threshold |
| ss_above_i | input | 1 | Soft-start level above the power-good delay threshold |
| fb_code_i | input | RAMP_W | Digitized feedback level (synchronous data) |
| ss_step_i | input | RAMP_W | Ramp increment per tick |
| sw_en_o | output | 1 | Switching allowed |
| gate_hiz_o | output | 1 | Request to release both gates to high impedance |
| ss_clr_o | output | 1 | Ramp forced to zero |
| pgood_o | output | 1 | Power good released (high) |
| latched_o | output | 1 | Locked off by overcurrent count or overvoltage |
| state_oh_o | output | 6 | One-hot state for debug |
| ss_level_o | output | RAMP_W | Soft-start ramp level |

## Verification
The bench builds the block with an 8-bit ramp, a reference code of 40 and a tick every second cycle. These values let a full soft start from a pre-biased level of 7 end in about fifteen cycles. With them, three restarts, an enable toggle and an overvoltage lockout fit in a few hundred cycles. OC_LIMIT stays at 3, so the lockout on the third event and the count that survives each restart are both reached. A stretch of random flag traffic then runs many crossings of restart, lockout and rail loss against the reference model.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    localparam int NUM_STATES = 6;
    localparam int NUM_FLAGS  = 7;

    // bit positions of the synchronized flag vector
    localparam int F_EN    = 0;
    localparam int F_RAILA = 1;
    localparam int F_RAILB = 2;
    localparam int F_OC    = 3;
    localparam int F_OV    = 4;
    localparam int F_UVOK  = 5;
    localparam int F_SSUP  = 6;

    typedef enum logic [2:0] {
        ST_OFF         = 3'd0,
        ST_SOFTSTART   = 3'd1,
        ST_REGULATE    = 3'd2,
        ST_OC_RESTART  = 3'd3,
        ST_LATCHED_OFF = 3'd4,
        ST_OV_LATCHED  = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        RAMP_TRACK = 2'd0,
        RAMP_CLEAR = 2'd1,
        RAMP_RUN   = 2'd2
    } ramp_mode_e;

    typedef struct packed {
        seq_state_e              state;
        logic                    sw_en;
        logic                    gate_hiz;
        logic                    ss_clr;
        logic                    pgood;
        logic                    latched;
        logic [NUM_STATES-1:0]   state_oh;
    } seq_regs_t;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int N      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));

    AST_OC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |-> (cnt_q < CW'(LIMIT))); // R5

    AST_OC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/ss_ramp.sv
module ss_ramp
    import buck_seq_pkg::*;
#(
    parameter int W        = 10,
    parameter int REF_CODE = 600,
    parameter int TICK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ramp_mode_e   mode_i,
    input  logic [W-1:0] fb_code_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] level_o,
    output logic         at_ref_o
);
    localparam logic [W:0]   REF_EXT = (W+1)'(REF_CODE);
    localparam logic [W-1:0] REF_LVL = W'(REF_CODE);

    logic [W-1:0] level_d, level_q;
    logic [W:0]   sum;
    logic         tick;

    generate
        if (TICK_DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divided
            localparam int TW = $clog2(TICK_DIV);
            logic [TW-1:0] tick_d, tick_q;
            assign tick = (tick_q == TW'(TICK_DIV - 1));
            always_comb begin
                if (mode_i != RAMP_RUN) tick_d = '0;
                else if (tick)          tick_d = '0;
                else                    tick_d = tick_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick_q <= '0;
                else        tick_q <= tick_d;
            end
        end
    endgenerate

    assign sum = {1'b0, level_q} + {1'b0, step_i};

    always_comb begin
        level_d = level_q;
        case (mode_i)
            RAMP_TRACK: level_d = fb_code_i;
            RAMP_CLEAR: level_d = '0;
            RAMP_RUN: begin
                if (tick) begin
                    if (sum >= REF_EXT) level_d = REF_LVL;
                    else                level_d = sum[W-1:0];
                end
            end
            default: level_d = level_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level_o  = level_q;
    assign at_ref_o = (level_q >= REF_LVL);

    AST_RAMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RAMP_CLEAR) |=> (level_q == '0)); // R3

    AST_RAMP_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RAMP_RUN && level_q <= REF_LVL) |=> (level_q <= REF_LVL)); // R9

    AST_RAMP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RAMP_TRACK) |=> (level_q == $past(fb_code_i))); // R8

endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import buck_seq_pkg::*;
#(
    parameter int RAMP_W      = 10,
    parameter int REF_CODE    = 600,
    parameter int TICK_DIV    = 4,
    parameter int OC_LIMIT    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rail_a_ok_i,
    input  logic              rail_b_ok_i,
    input  logic              oc_i,
    input  logic              ov_i,
    input  logic              uv_ok_i,
    input  logic              ss_above_i,
    input  logic [RAMP_W-1:0] fb_code_i,
    input  logic [RAMP_W-1:0] ss_step_i,
    output logic              sw_en_o,
    output logic              gate_hiz_o,
    output logic              ss_clr_o,
    output logic              pgood_o,
    output logic              latched_o,
    output logic [5:0]        state_oh_o,
    output logic [RAMP_W-1:0] ss_level_o
);
    localparam logic [NUM_STATES-1:0] OH_RESET = NUM_STATES'(1);

    logic [NUM_FLAGS-1:0] raw_flags, s_flags;
    seq_regs_t            cur_d, cur_q;
    seq_state_e           nxt_state;
    ramp_mode_e           ramp_mode;
    logic                 supply_ok, s_en, s_oc, s_ov;
    logic                 running_q, running_d;
    logic                 oc_inc, oc_clr, oc_last, at_ref;

    assign raw_flags[F_EN]    = en_i;
    assign raw_flags[F_RAILA] = rail_a_ok_i;
    assign raw_flags[F_RAILB] = rail_b_ok_i;
    assign raw_flags[F_OC]    = oc_i;
    assign raw_flags[F_OV]    = ov_i;
    assign raw_flags[F_UVOK]  = uv_ok_i;
    assign raw_flags[F_SSUP]  = ss_above_i;

    flag_sync #(.N(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (s_flags)
    );

    assign supply_ok = s_flags[F_RAILA] & s_flags[F_RAILB];
    assign s_en      = s_flags[F_EN];
    assign s_oc      = s_flags[F_OC];
    assign s_ov      = s_flags[F_OV];
    assign running_q = (cur_q.state == ST_SOFTSTART) || (cur_q.state == ST_REGULATE);

    // an overcurrent is counted only where it causes a restart
    assign oc_inc = running_q & supply_ok & s_en & ~s_ov & s_oc;
    assign oc_clr = ~supply_ok | ~s_en;

    oc_counter #(.LIMIT(OC_LIMIT)) u_occnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (oc_clr),
        .inc_i  (oc_inc),
        .last_o (oc_last)
    );

    always_comb begin
        case (cur_q.state)
            ST_OFF:                     ramp_mode = RAMP_TRACK;
            ST_SOFTSTART, ST_REGULATE:  ramp_mode = RAMP_RUN;
            default:                    ramp_mode = RAMP_CLEAR;
        endcase
    end

    ss_ramp #(.W(RAMP_W), .REF_CODE(REF_CODE), .TICK_DIV(TICK_DIV)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (ramp_mode),
        .fb_code_i (fb_code_i),
        .step_i    (ss_step_i),
        .level_o   (ss_level_o),
        .at_ref_o  (at_ref)
    );

    // next-state decision
    always_comb begin
        nxt_state = cur_q.state;
        if (!supply_ok) begin
            nxt_state = ST_OFF;
        end else begin
            case (cur_q.state)
                ST_OFF: begin
                    if (s_en) nxt_state = ST_SOFTSTART;
                end
                ST_SOFTSTART, ST_REGULATE: begin
                    if (s_ov)         nxt_state = ST_OV_LATCHED;
                    else if (!s_en)   nxt_state = ST_OFF;
                    else if (s_oc)    nxt_state = oc_last ? ST_LATCHED_OFF : ST_OC_RESTART;
                    else if (cur_q.state == ST_SOFTSTART && at_ref)
                                      nxt_state = ST_REGULATE;
                end
                ST_OC_RESTART: begin
                    if (s_ov)         nxt_state = ST_OV_LATCHED;
                    else if (!s_en)   nxt_state = ST_OFF;
                    else              nxt_state = ST_SOFTSTART;
                end
                ST_LATCHED_OFF: begin
                    if (!s_en)        nxt_state = ST_OFF;
                end
                ST_OV_LATCHED: nxt_state = ST_OV_LATCHED;
                default:       nxt_state = ST_OFF;
            endcase
        end
    end

    // registered outputs derived from the next state
    assign running_d = (nxt_state == ST_SOFTSTART) || (nxt_state == ST_REGULATE);

    always_comb begin
        cur_d          = cur_q;
        cur_d.state    = nxt_state;
        cur_d.sw_en    = running_d;
        cur_d.gate_hiz = (nxt_state == ST_OC_RESTART) || (nxt_state == ST_LATCHED_OFF);
        cur_d.ss_clr   = (nxt_state == ST_OC_RESTART) || (nxt_state == ST_LATCHED_OFF)
                         || (nxt_state == ST_OV_LATCHED);
        cur_d.pgood    = running_d & s_flags[F_SSUP] & s_flags[F_UVOK];
        cur_d.latched  = (nxt_state == ST_LATCHED_OFF) || (nxt_state == ST_OV_LATCHED);
        for (int i = 0; i < NUM_STATES; i++) begin
            cur_d.state_oh[i] = (nxt_state == seq_state_e'(3'(i)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.state    <= ST_OFF;
            cur_q.state_oh <= OH_RESET;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign sw_en_o    = cur_q.sw_en;
    assign gate_hiz_o = cur_q.gate_hiz;
    assign ss_clr_o   = cur_q.ss_clr;
    assign pgood_o    = cur_q.pgood;
    assign latched_o  = cur_q.latched;
    assign state_oh_o = cur_q.state_oh;

    AST_RAIL_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (cur_q.state == ST_OFF && !sw_en_o)); // R2

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OV_LATCHED && supply_ok) |=> (cur_q.state == ST_OV_LATCHED)); // R7

    AST_PGOOD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> sw_en_o); // R6

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh_o) == 1); // R11

    AST_LATCH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_LATCHED_OFF && $past(cur_q.state) != ST_LATCHED_OFF)
        |-> $past(oc_last)); // R4

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OFF && !(supply_ok && s_en)) |=> !sw_en_o); // R1

endmodule

// File: tb/tb_buck_seq_ctrl.sv
module tb_buck_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int REF  = 40;
    localparam int DIV  = 2;
    localparam int LIM  = 3;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, ra = 0, rb = 0, oc = 0, ov = 0, uvok = 0, ssup = 0;
    logic [W-1:0] fb = '0, step = '0;
    logic sw_en, hiz, ssclr, pg, lat;
    logic [5:0] oh;
    logic [W-1:0] lvl;

    int compared = 0;
    int mismatched = 0;
    string phase = "R11";

    buck_seq_ctrl #(.RAMP_W(W), .REF_CODE(REF), .TICK_DIV(DIV), .OC_LIMIT(LIM),
                    .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .rail_a_ok_i(ra), .rail_b_ok_i(rb),
        .oc_i(oc), .ov_i(ov), .uv_ok_i(uvok), .ss_above_i(ssup),
        .fb_code_i(fb), .ss_step_i(step),
        .sw_en_o(sw_en), .gate_hiz_o(hiz), .ss_clr_o(ssclr), .pgood_o(pg),
        .latched_o(lat), .state_oh_o(oh), .ss_level_o(lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    // states: 0 off, 1 soft start, 2 regulate, 3 oc restart, 4 latched, 5 ov latched
    int m_st = 0, m_lvl = 0, m_cnt = 0, m_tick = 0;
    int m_pg = 0;
    int fifo_en[$], fifo_ra[$], fifo_rb[$], fifo_oc[$], fifo_ov[$], fifo_uv[$], fifo_su[$];

    task automatic fifo_reset();
        fifo_en = {}; fifo_ra = {}; fifo_rb = {}; fifo_oc = {};
        fifo_ov = {}; fifo_uv = {}; fifo_su = {};
        for (int i = 0; i < SYNC; i++) begin
            fifo_en.push_back(0); fifo_ra.push_back(0); fifo_rb.push_back(0);
            fifo_oc.push_back(0); fifo_ov.push_back(0); fifo_uv.push_back(0);
            fifo_su.push_back(0);
        end
    endtask

    initial fifo_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_lvl = 0; m_cnt = 0; m_tick = 0; m_pg = 0;
            fifo_reset();
        end else begin
            int e, pwr, o_c, o_v, nst;
            bit run;
            e   = fifo_en[0];
            pwr = fifo_ra[0] & fifo_rb[0];
            o_c = fifo_oc[0];
            o_v = fifo_ov[0];
            run = (m_st == 1 || m_st == 2);
            nst = m_st;
            if (!pwr) nst = 0;
            else if (m_st == 0) nst = e ? 1 : 0;
            else if (run) begin
                if (o_v) nst = 5;
                else if (!e) nst = 0;
                else if (o_c) nst = (m_cnt + 1 >= LIM) ? 4 : 3;
                else if (m_st == 1 && m_lvl >= REF) nst = 2;
            end else if (m_st == 3) nst = o_v ? 5 : (!e ? 0 : 1);
            else if (m_st == 4) nst = e ? 4 : 0;
            // restart counter
            if (!pwr || !e) m_cnt = 0;
            else if (run && !o_v && o_c) m_cnt++;
            // ramp follows the state held before this edge
            if (m_st == 0) begin
                m_lvl = int'(fb); m_tick = 0;
            end else if (run) begin
                if (m_tick == DIV - 1) begin
                    m_tick = 0;
                    m_lvl = (m_lvl + int'(step) >= REF) ? REF : m_lvl + int'(step);
                end else m_tick++;
            end else begin
                m_lvl = 0; m_tick = 0;
            end
            m_st = nst;
            m_pg = ((nst == 1 || nst == 2) && fifo_su[0] && fifo_uv[0]) ? 1 : 0;
            void'(fifo_en.pop_front()); fifo_en.push_back(int'(en));
            void'(fifo_ra.pop_front()); fifo_ra.push_back(int'(ra));
            void'(fifo_rb.pop_front()); fifo_rb.push_back(int'(rb));
            void'(fifo_oc.pop_front()); fifo_oc.push_back(int'(oc));
            void'(fifo_ov.pop_front()); fifo_ov.push_back(int'(ov));
            void'(fifo_uv.pop_front()); fifo_uv.push_back(int'(uvok));
            void'(fifo_su.pop_front()); fifo_su.push_back(int'(ssup));
        end
    end

    task automatic check(string what, string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s [%s / phase %s] actual=%0d expected=%0d at %0t",
                     what, tag, phase, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("sw_en",    "R1",  int'(sw_en), (m_st == 1 || m_st == 2) ? 1 : 0);
            check("gate_hiz", "R3",  int'(hiz),   (m_st == 3 || m_st == 4) ? 1 : 0);
            check("ss_clr",   "R3",  int'(ssclr), (m_st >= 3) ? 1 : 0);
            check("pgood",    "R6",  int'(pg),    m_pg);
            check("latched",  "R4",  int'(lat),   (m_st >= 4) ? 1 : 0);
            check("state_oh", "R11", int'(oh),    1 << m_st);
            check("ss_level", "R9",  int'(lvl),   m_lvl);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_oc();
        oc = 1; cyc(1); oc = 0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog [R10] actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        phase = "R11";
        check("reset oh", "R11", int'(oh), 1);
        check("reset outputs", "R11", int'({sw_en, hiz, ssclr, pg, lat}), 0);

        phase = "R8";
        ra = 1; fb = 8'd7; step = 8'd5;
        cyc(6);
        check("ramp tracks fb", "R8", int'(lvl), 7);

        phase = "R1";
        en = 1;
        cyc(6);
        check("no start with rail b low", "R1", int'(sw_en), 0);
        phase = "R10";
        rb = 1;
        cyc(2);
        check("sync latency, before", "R10", int'(sw_en), 0);
        cyc(1);
        check("sync latency, after", "R10", int'(sw_en), 1);
        check("enters soft start", "R1", int'(oh), 2);

        phase = "R9";
        cyc(30);
        check("ramp at reference", "R9", int'(lvl), REF);
        check("regulating", "R9", int'(oh), 4);

        phase = "R6";
        ssup = 1; uvok = 1;
        cyc(4);
        check("pgood released", "R6", int'(pg), 1);
        uvok = 0;
        cyc(4);
        check("pgood needs uv flag", "R6", int'(pg), 0);
        uvok = 1;

        phase = "R3";
        pulse_oc();
        cyc(2);
        check("restart gates hiz", "R3", int'(hiz), 1);
        cyc(1);
        check("ramp cleared", "R3", int'(lvl), 0);
        cyc(30);
        phase = "R5";
        pulse_oc();
        cyc(30);
        en = 0; cyc(4); en = 1;
        cyc(30);
        pulse_oc(); cyc(30);
        pulse_oc(); cyc(30);
        check("count cleared by enable", "R5", int'(lat), 0);
        phase = "R4";
        pulse_oc();
        cyc(5);
        check("third event latches", "R4", int'(lat), 1);
        check("latched state", "R4", int'(oh), 16);
        cyc(20);
        check("latch holds", "R4", int'(hiz), 1);

        phase = "R12";
        en = 0; cyc(5);
        check("enable low leaves latch", "R12", int'(oh), 1);
        en = 1; cyc(30);
        en = 0; cyc(4);
        check("enable low stops switching", "R12", int'(sw_en), 0);
        en = 1; cyc(30);

        phase = "R2";
        ra = 0; cyc(1); ra = 1;
        cyc(2);
        check("rail loss to off", "R2", int'(oh), 1);
        cyc(30);

        phase = "R7";
        ov = 1; cyc(1); ov = 0;
        cyc(4);
        check("ov latched", "R7", int'(oh), 32);
        check("ov pgood low", "R7", int'(pg), 0);
        en = 0; cyc(5); en = 1; cyc(5);
        check("enable toggle ignored", "R7", int'(lat), 1);
        rb = 0; cyc(4);
        check("rail loss clears ov", "R2", int'(oh), 1);
        rb = 1; cyc(30);
        check("restart after ov", "R7", int'(oh), 4);

        phase = "R10";
        for (int k = 0; k < 600; k++) begin
            en   = ($urandom_range(0, 19) != 0);
            ra   = ($urandom_range(0, 39) != 0);
            rb   = ($urandom_range(0, 39) != 0);
            oc   = ($urandom_range(0, 14) == 0);
            ov   = ($urandom_range(0, 79) == 0);
            uvok = ($urandom_range(0, 5) != 0);
            ssup = ($urandom_range(0, 3) != 0);
            fb   = W'($urandom_range(0, 60));
            step = W'($urandom_range(0, 9));
            cyc(1);
        end
        cyc(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule